// File: doc/BRIEF.md
# DRAM Supply-Current Command Loop Sequencer

This block drives the command, bank and address pins of a DDR3-style memory with an endless single-bank loop, so that the supply current of the device can be measured under a known activity pattern. In the first mode it issues activate, then precharge. In the second mode it issues activate, then read, then precharge. Every cycle between two commands is a deselect filler. In filler cycles the command strobes and the address bits other than bit 10 swing between a pattern and its inverse, so the inputs keep switching.

The controlling logic gives the loop timing in clock cycles: row-active time, activate-to-read delay, activate-to-activate period and read latency. It then holds `run_en` high. The block samples these settings when each loop begins and repeats the loop until `run_en` is low at the end of a loop. A read-data-valid strobe marks the four clocks of each eight-beat read burst. Mode-register set-up, refresh and the data pads belong to other logic.

Top module: `dram_cmdloop`

## Requirements
- R1: While `rst` is high, `cke` is 0, `cs_n`, `ras_n`, `cas_n` and `we_n` are 1, and `ba`, `addr` and `rd_valid` are 0. From the first clock after reset onward, `cke` is 1 in every cycle.
- R2: If `run_en` is high while the block is idle, an activate appears on the pins after the next rising edge. An activate is `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=1, with `addr` equal to `ROW_ADDR` with bit 10 cleared. That cycle is loop position 0.
- R3: A precharge appears at loop position E_RAS = max(`t_ras`,1). A precharge is `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr` equal to `ROW_ADDR` with bit 10 cleared.
- R4: The loop lasts E_RC = max(`t_rc`, E_RAS+1) cycles. The next activate falls at position E_RC.
- R5: With `mode_sel`=1 and 1 <= `t_rcd` < E_RAS, a read appears at position `t_rcd`. A read is `cs_n`=0, `ras_n`=1, `cas_n`=0, `we_n`=1, with `addr` equal to `COL_ADDR` with bit 10 cleared. No read is issued when `mode_sel`=0 or when `t_rcd` is outside that range.
- R6: Every other position inside a loop is a filler. A filler has `cs_n`=1. Let p be bit 0 of the position. Then `ras_n`=p, `we_n`=p and `cas_n`=!p. `addr` is `FILL_PAT` when p=1 and the bitwise inverse of `FILL_PAT` when p=0, with bit 10 cleared in both cases.
- R7: `ba` is 0 and `addr[10]` is 0 in every cycle.
- R8: `rd_valid` is high in the cycles that lie E_CL to E_CL+3 cycles after each read, where E_CL = max(`cas_lat`,1). Windows from successive reads that overlap or touch merge into one continuous high period.
- R9: If `run_en` is low in the last cycle of a loop, the block returns to idle after that loop. Idle is `cs_n`, `ras_n`, `cas_n` and `we_n` at 1 and `addr` and `ba` at 0. An `rd_valid` window that has already started still finishes.
- R10: `mode_sel`, `t_ras`, `t_rcd`, `t_rc` and `cas_lat` are sampled at the edge that puts each activate on the pins. Changes to them later in that loop have no effect on that loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start the loop when idle, continue at each loop end |
| mode_sel | input | 1 | 0: activate/precharge loop, 1: activate/read/precharge loop |
| t_ras | input | TW | Activate-to-precharge cycles |
| t_rcd | input | TW | Activate-to-read cycles |
| t_rc | input | TW | Activate-to-activate cycles |
| cas_lat | input | CLW | Read-to-data cycles |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BW | Bank address |
| addr | output | AW | Row/column address |
| rd_valid | output | 1 | Read burst data window |

## Verification
The read-data window of one loop can fall in the same cycles as the next loop's activate and read. The bench forces this with a short loop period, a one-cycle activate-to-read delay and a long read latency. It then checks that `rd_valid` stays high without a gap across the merged windows while the command pins still follow the new loop. A second overlap is `run_en` dropping partway through a loop while a burst window is still pending. Here the bench checks that the precharge is still issued, that the bus then goes idle, and that the strobe still runs its full length.

// File: rtl/cmdloop_pkg.sv
package cmdloop_pkg;
  typedef enum logic [2:0] {K_IDLE, K_ACT, K_RD, K_PRE, K_FILL} kind_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pins_t PINS_ACT  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam pins_t PINS_RD   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
  localparam pins_t PINS_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
endpackage

// File: rtl/cl_loop_ctr.sv
module cl_loop_ctr #(
  parameter int TW  = 6,
  parameter int CLW = 4,
  localparam int CW = TW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  input  logic           mode_i,
  input  logic [TW-1:0]  tras_i,
  input  logic [TW-1:0]  trcd_i,
  input  logic [TW-1:0]  trc_i,
  input  logic [CLW-1:0] cl_i,
  output logic           nxt_run,
  output logic [CW-1:0]  nxt_pos,
  output logic [CW-1:0]  tras_e,
  output logic [TW-1:0]  trcd_q,
  output logic [CLW-1:0] cl_e,
  output logic           rd_ok
);
  logic           run_q;
  logic [CW-1:0]  pos_q;
  logic           mode_q;
  logic [TW-1:0]  tras_q, trc_q;
  logic [CLW-1:0] cl_q;
  logic [CW-1:0]  trc_e;
  logic           at_end;

  always_comb begin
    tras_e = (tras_q == '0) ? CW'(1) : {1'b0, tras_q};
    trc_e  = ({1'b0, trc_q} > tras_e) ? {1'b0, trc_q} : tras_e + CW'(1);
    cl_e   = (cl_q == '0) ? CLW'(1) : cl_q;
    rd_ok  = mode_q && (trcd_q != '0) && ({1'b0, trcd_q} < tras_e);
    at_end = (pos_q == trc_e - CW'(1));
    if (!run_q || at_end) begin
      nxt_run = run_en;
      nxt_pos = '0;
    end else begin
      nxt_run = 1'b1;
      nxt_pos = pos_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      mode_q <= 1'b0;
      tras_q <= '0;
      trcd_q <= '0;
      trc_q  <= '0;
      cl_q   <= '0;
    end else begin
      run_q <= nxt_run;
      pos_q <= nxt_pos;
      if (nxt_run && nxt_pos == '0) begin
        mode_q <= mode_i;
        tras_q <= tras_i;
        trcd_q <= trcd_i;
        trc_q  <= trc_i;
        cl_q   <= cl_i;
      end
    end
  end

  // R4: a new loop inside a run begins only after the full period
  p_act_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && nxt_run && nxt_pos == '0) |-> (pos_q == trc_e - CW'(1)));

  // R9: the run never stops partway through a loop
  p_stop_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    (run_q && !nxt_run) |-> at_end);
endmodule

// File: rtl/cl_cmd_enc.sv
module cl_cmd_enc
  import cmdloop_pkg::*;
#(
  parameter int AW   = 14,
  parameter int BW   = 3,
  parameter int TW   = 6,
  parameter int A10  = 10,
  parameter logic [AW-1:0] ROW_ADDR = 14'h1A5C,
  parameter logic [AW-1:0] COL_ADDR = 14'h0478,
  parameter logic [AW-1:0] FILL_PAT = 14'h2AAA,
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nxt_run,
  input  logic [CW-1:0] nxt_pos,
  input  logic [CW-1:0] tras_e,
  input  logic [TW-1:0] trcd_q,
  input  logic          rd_ok,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [BW-1:0] ba,
  output logic [AW-1:0] addr,
  output logic          rd_q
);
  localparam logic [AW-1:0] KEEP = ~(AW'(1) << A10);

  kind_t         kind_d, kind_q;
  pins_t         pins_d;
  logic [AW-1:0] addr_d;
  logic          ph;

  always_comb begin
    ph = nxt_pos[0];
    if (!nxt_run)                                   kind_d = K_IDLE;
    else if (nxt_pos == '0)                         kind_d = K_ACT;
    else if (nxt_pos == tras_e)                     kind_d = K_PRE;
    else if (rd_ok && nxt_pos == {1'b0, trcd_q})    kind_d = K_RD;
    else                                            kind_d = K_FILL;
    case (kind_d)
      K_ACT:   begin pins_d = PINS_ACT; addr_d = ROW_ADDR & KEEP; end
      K_PRE:   begin pins_d = PINS_PRE; addr_d = ROW_ADDR & KEEP; end
      K_RD:    begin pins_d = PINS_RD;  addr_d = COL_ADDR & KEEP; end
      K_FILL:  begin
        pins_d = '{cs_n: 1'b1, ras_n: ph, cas_n: ~ph, we_n: ph};
        addr_d = (ph ? FILL_PAT : ~FILL_PAT) & KEEP;
      end
      default: begin pins_d = PINS_IDLE; addr_d = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke    <= 1'b0;
      kind_q <= K_IDLE;
      cs_n   <= 1'b1;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      we_n   <= 1'b1;
      addr   <= '0;
      rd_q   <= 1'b0;
    end else begin
      cke    <= 1'b1;
      kind_q <= kind_d;
      cs_n   <= pins_d.cs_n;
      ras_n  <= pins_d.ras_n;
      cas_n  <= pins_d.cas_n;
      we_n   <= pins_d.we_n;
      addr   <= addr_d;
      rd_q   <= (kind_d == K_RD);
    end
  end

  assign ba = '0;

  // checker state: cycles since the activate now on the pins
  logic [CW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                    age_q <= '0;
    else if (kind_d == K_ACT)   age_q <= '0;
    else if (age_q != '1)       age_q <= age_q + CW'(1);
  end

  // R3: precharge sits exactly the row-active time after its activate
  p_pre_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_PRE) |-> (age_q == tras_e));

  // R1: clock enable stays high once out of reset
  p_cke_high_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cke);

  // R7: bit 10 is low whenever a command is driven
  p_a10_low_r7: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !addr[A10]);

  // R6: successive fillers drive inverted strobes
  p_fill_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_FILL && $past(kind_q) == K_FILL) |-> (ras_n != $past(ras_n)));
endmodule

// File: rtl/cl_rdv_pipe.sv
module cl_rdv_pipe #(
  parameter int CLW = 4,
  localparam int CL_MAX = (1 << CLW) - 1,
  localparam int HL = CL_MAX + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_q,
  input  logic [CLW-1:0] cl_e,
  output logic           rd_valid
);
  logic [HL-2:0] hist_q;
  logic [HL-1:0] vec, sh;
  logic          vld_d;

  always_comb begin
    vec   = {hist_q, rd_q};
    sh    = vec >> (cl_e - CLW'(1));
    vld_d = |sh[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= '0;
      rd_valid <= 1'b0;
    end else begin
      hist_q   <= vec[HL-2:0];
      rd_valid <= vld_d;
    end
  end

  // R8: every high period lasts at least four clocks
  p_burst_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_valid) |-> $past(rd_valid, 4));

  // R8: the strobe never rises without a read before it
  p_rise_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> (vec != '0 || hist_q != '0));
endmodule

// File: rtl/dram_cmdloop.sv
module dram_cmdloop #(
  parameter int AW  = 14,
  parameter int BW  = 3,
  parameter int TW  = 6,
  parameter int CLW = 4,
  parameter logic [AW-1:0] ROW_ADDR = 14'h1A5C,
  parameter logic [AW-1:0] COL_ADDR = 14'h0478,
  parameter logic [AW-1:0] FILL_PAT = 14'h2AAA
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  input  logic           mode_sel,
  input  logic [TW-1:0]  t_ras,
  input  logic [TW-1:0]  t_rcd,
  input  logic [TW-1:0]  t_rc,
  input  logic [CLW-1:0] cas_lat,
  output logic           cke,
  output logic           cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [BW-1:0]  ba,
  output logic [AW-1:0]  addr,
  output logic           rd_valid
);
  localparam int CW = TW + 1;

  logic           nxt_run, rd_ok, rd_q;
  logic [CW-1:0]  nxt_pos, tras_e;
  logic [TW-1:0]  trcd_q;
  logic [CLW-1:0] cl_e;

  cl_loop_ctr #(.TW(TW), .CLW(CLW)) u_ctr (
    .clk(clk), .rst(rst), .run_en(run_en), .mode_i(mode_sel),
    .tras_i(t_ras), .trcd_i(t_rcd), .trc_i(t_rc), .cl_i(cas_lat),
    .nxt_run(nxt_run), .nxt_pos(nxt_pos), .tras_e(tras_e),
    .trcd_q(trcd_q), .cl_e(cl_e), .rd_ok(rd_ok)
  );

  cl_cmd_enc #(.AW(AW), .BW(BW), .TW(TW), .A10(10), .ROW_ADDR(ROW_ADDR),
               .COL_ADDR(COL_ADDR), .FILL_PAT(FILL_PAT)) u_enc (
    .clk(clk), .rst(rst), .nxt_run(nxt_run), .nxt_pos(nxt_pos),
    .tras_e(tras_e), .trcd_q(trcd_q), .rd_ok(rd_ok),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .rd_q(rd_q)
  );

  cl_rdv_pipe #(.CLW(CLW)) u_rdv (
    .clk(clk), .rst(rst), .rd_q(rd_q), .cl_e(cl_e), .rd_valid(rd_valid)
  );
endmodule

// File: tb/sim_dram_cmdloop.sv
module sim_dram_cmdloop;
  localparam logic [13:0] ROW  = 14'h1A5C;
  localparam logic [13:0] COL  = 14'h0478;
  localparam logic [13:0] FILL = 14'h2AAA;
  localparam logic [13:0] KEEP = ~(14'h0001 << 10);

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b0, mode_sel = 1'b0;
  logic [5:0] t_ras = 6'd15, t_rcd = 6'd5, t_rc = 6'd20;
  logic [3:0] cas_lat = 4'd5;
  logic cke, cs_n, ras_n, cas_n, we_n, rd_valid;
  logic [2:0] ba;
  logic [13:0] addr;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_cmdloop u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .mode_sel(mode_sel),
    .t_ras(t_ras), .t_rcd(t_rcd), .t_rc(t_rc), .cas_lat(cas_lat),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .rd_valid(rd_valid)
  );

  task automatic chk(string req, logic [22:0] exp);
    logic [22:0] got = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, rd_valid};
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [22:0] pk(logic [3:0] p, logic [13:0] a, logic v);
    return {1'b1, p, 3'b000, a, v};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset", {1'b0, 4'b1111, 3'b000, 14'h0, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", pk(4'b1111, 14'h0, 1'b0));
    repeat (3) @(negedge clk);
    chk("R9 idle without run_en", pk(4'b1111, 14'h0, 1'b0));
  endtask

  // one scenario: nl loops then stop; scr scrambles inputs inside each loop (R10)
  task automatic run_case(string nm, bit md, int ras, int rcd, int rc, int cl,
                          int nl, bit scr);
    int tre  = (ras < 1) ? 1 : ras;
    int trce = (rc > tre) ? rc : tre + 1;
    int cle  = (cl < 1) ? 1 : cl;
    bit rok  = md && rcd >= 1 && rcd < tre;
    int total = nl * trce + cle + 6;
    @(negedge clk);
    mode_sel = md; t_ras = 6'(ras); t_rcd = 6'(rcd); t_rc = 6'(rc);
    cas_lat = 4'(cl); run_en = 1'b1;
    for (int c = 0; c < total; c++) begin
      logic [3:0] p;
      logic [13:0] a;
      logic v = 1'b0;
      string rq;
      int pos = c % trce;
      @(negedge clk);
      for (int l = 0; l < nl; l++) begin
        int d = c - (l * trce + rcd);
        if (rok && d >= cle && d <= cle + 3) v = 1'b1;
      end
      if (c >= nl * trce) begin
        p = 4'b1111; a = 14'h0; rq = "R9 idle after stop";
      end else if (pos == 0) begin
        p = 4'b0011; a = ROW & KEEP; rq = (c == 0) ? "R2 activate" : "R4 next activate";
      end else if (pos == tre) begin
        p = 4'b0010; a = ROW & KEEP; rq = "R3 precharge";
      end else if (rok && pos == rcd) begin
        p = 4'b0101; a = COL & KEEP; rq = "R5 read";
      end else begin
        logic ph = pos[0];
        p = {1'b1, ph, ~ph, ph};
        a = (ph ? FILL : ~FILL) & KEEP; rq = "R6 filler";
      end
      chk($sformatf("%s %s R7 R8 c=%0d", nm, rq, c), pk(p, a, v));
      if (scr && c < nl * trce) begin
        if (pos == 1) begin
          mode_sel = ~md; t_ras = 6'd2; t_rcd = 6'd1; t_rc = 6'd3;
        end
        if (pos == trce - 1) begin
          mode_sel = md; t_ras = 6'(ras); t_rcd = 6'(rcd); t_rc = 6'(rc);
        end
      end
      if (c == (nl - 1) * trce) run_en = 1'b0;
    end
  endtask

  initial begin
    t_reset();
    run_case("mode0 base R10", 1'b0, 15, 5, 20, 5, 2, 1'b1);
    run_case("mode1 base R10", 1'b1, 15, 5, 20, 5, 2, 1'b1);
    run_case("rc below ras R4", 1'b0, 4, 0, 2, 3, 3, 1'b0);
    run_case("cl zero R8", 1'b1, 4, 2, 2, 0, 2, 1'b0);
    run_case("merged windows R8", 1'b1, 3, 1, 2, 6, 3, 1'b0);
    run_case("rcd too late R5", 1'b1, 3, 3, 5, 2, 2, 1'b0);
    run_case("ras zero R3", 1'b0, 0, 0, 0, 1, 2, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule